// File: doc/BRIEF.md
# Per-Source Edge/Level Interrupt Controller

This block collects eight independent condition inputs into one interrupt request. Each source has an enable bit and a 2-bit trigger code. The code selects whether the source fires when its condition appears, when it goes away, or for as long as it is present. The two bits of each source's code are held in two separate mode registers, one for the high bits and one for the low bits, at the same bit position as the source.

Edge-triggered sources latch a sticky status bit, which software clears by reading the status register. Level-triggered sources show the live condition in their status bit. The request output is asserted whenever any status bit is set. A separate polarity setting decides how that request appears at the pin: active high, active low, or open-drain active low. In the open-drain case the request is carried on an output-enable signal.

Software reaches the configuration and status through a simple register port with single-cycle write and read strobes. Read data appears one clock after the read strobe.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After synchronous reset, the enable, mode-high, mode-low and polarity registers read 0 and the status reads 0. The output is then inactive: irq_o=0 and irq_oe=1.
- R2: Register addresses are fixed.
  - 0 is the enable mask.
  - 1 holds the mode high bits.
  - 2 holds the mode low bits.
  - 3 holds the polarity in bits [1:0]; the upper bits read 0.
  - 4 is the status register.
  - Any other address reads 0.
  - A write to address 4 is ignored.
  - reg_rdata is valid in the cycle after reg_rd_en and returns the value the register held before that clock edge.
- R3: With code 00, a rising condition (input 1 at this edge, 0 at the previous edge) sets the source's status bit at that edge. The previous sample resets to 0.
- R4: With code 01, a falling condition (input 0 at this edge, 1 at the previous edge) sets the source's status bit at that edge.
- R5: With code 10, the status bit equals the condition sampled at the previous edge. It is not sticky, and reading does not clear it.
- R6: The trigger code of source i is {mode_hi[i], mode_lo[i]}, so sources on the same registers can use different modes.
- R7: A source with enable bit 0, or with reserved code 11, holds its status bit at 0 from the next edge on. This also discards an already latched bit, and it never drives the output.
- R8: A status read returns the pre-clear value and clears the edge-mode bits it returns. If a new edge arrives in the same cycle as that read, its bit stays set.
- R9: The request is active exactly when at least one status bit is 1.
- R10: Polarity code behaviour:
  - 00 drives irq_o = request with irq_oe=1.
  - 01 drives irq_o = not request with irq_oe=1.
  - 10 holds irq_o=0 and drives irq_oe = request (open drain).
  - 11 behaves as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 8 | Condition inputs, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The collision that matters here is a read-to-clear of the status register landing in the same cycle as a new qualifying edge on a source whose bit is being cleared. The bench produces it directly: it raises a condition in the same cycle as a status read, then reads again. The first read must return the old value and the second must show the bit still set. The random phase issues frequent status reads against toggling conditions, so the collision also recurs with mixed modes, and a reference model judges every read and every output sample.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned NUM_SRC_DEF = 8;
    localparam int unsigned ADDR_W      = 3;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        POL_HIGH       = 2'b00,
        POL_LOW        = 2'b01,
        POL_OPEN_DRAIN = 2'b10,
        POL_SPARE      = 2'b11
    } out_pol_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_ENABLE   = 3'd0,
        ADDR_MODE_HI  = 3'd1,
        ADDR_MODE_LO  = 3'd2,
        ADDR_POLARITY = 3'd3,
        ADDR_STATUS   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic level;
        logic oe;
    } pin_drv_t;

    function automatic trig_mode_e mode_of(input logic hi, input logic lo);
        return trig_mode_e'({hi, lo});
    endfunction

    function automatic pin_drv_t drive_of(input out_pol_e pol, input logic req);
        pin_drv_t d;
        case (pol)
            POL_LOW:        begin d.level = ~req; d.oe = 1'b1; end
            POL_OPEN_DRAIN: begin d.level = 1'b0; d.oe = req;  end
            default:        begin d.level = req;  d.oe = 1'b1; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] mode_hi_q,
    output logic [NUM_SRC-1:0] mode_lo_q,
    output out_pol_e           pol_q,
    output logic [NUM_SRC-1:0] rdata,
    output logic               status_clr
);
    localparam int unsigned PAD_W = NUM_SRC - 2;

    logic [NUM_SRC-1:0] rd_mux;

    assign status_clr = rd_en && (addr == ADDR_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            mode_hi_q <= '0;
            mode_lo_q <= '0;
            pol_q     <= POL_HIGH;
        end else if (wr_en) begin
            case (addr)
                ADDR_ENABLE:   en_q      <= wdata;
                ADDR_MODE_HI:  mode_hi_q <= wdata;
                ADDR_MODE_LO:  mode_lo_q <= wdata;
                ADDR_POLARITY: pol_q     <= out_pol_e'(wdata[1:0]);
                default:       ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_ENABLE:   rd_mux = en_q;
            ADDR_MODE_HI:  rd_mux = mode_hi_q;
            ADDR_MODE_LO:  rd_mux = mode_lo_q;
            ADDR_POLARITY: rd_mux = {{PAD_W{1'b0}}, pol_q};
            ADDR_STATUS:   rd_mux = status;
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/evt_edge_sampler.sv
module evt_edge_sampler
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cond_i,
    output logic [NUM_SRC-1:0] cond_prev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cond_prev <= '0;
        end else begin
            cond_prev <= cond_i;
        end
    end
endmodule

// File: rtl/evt_src_cell.sv
module evt_src_cell
    import evt_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond,
    input  logic       cond_prev,
    input  logic       enable,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       status
);
    logic hit;
    logic nxt;

    always_comb begin
        hit = 1'b0;
        nxt = 1'b0;
        if (enable) begin
            case (mode)
                TRIG_RISE: begin
                    hit = cond & ~cond_prev;
                    nxt = hit | (status & ~clr);
                end
                TRIG_FALL: begin
                    hit = ~cond & cond_prev;
                    nxt = hit | (status & ~clr);
                end
                TRIG_LEVEL: nxt = cond;
                default:    nxt = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else begin
            status <= nxt;
        end
    end
endmodule

// File: rtl/evt_out_drive.sv
module evt_out_drive
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
    input  logic [NUM_SRC-1:0] status,
    input  out_pol_e           pol,
    output logic               irq_o,
    output logic               irq_oe
);
    pin_drv_t drv;

    always_comb begin
        drv    = drive_of(pol, |status);
        irq_o  = drv.level;
        irq_oe = drv.oe;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_o,
    output logic               irq_oe
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] mode_hi_q;
    logic [NUM_SRC-1:0] mode_lo_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] cond_prev;
    out_pol_e           pol_q;
    logic               status_clr;

    evt_regfile #(.NUM_SRC(NUM_SRC)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status     (status_q),
        .en_q       (en_q),
        .mode_hi_q  (mode_hi_q),
        .mode_lo_q  (mode_lo_q),
        .pol_q      (pol_q),
        .rdata      (reg_rdata),
        .status_clr (status_clr)
    );

    evt_edge_sampler #(.NUM_SRC(NUM_SRC)) smp_i (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond_i),
        .cond_prev (cond_prev)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        evt_src_cell cell_i (
            .clk       (clk),
            .rst       (rst),
            .cond      (cond_i[i]),
            .cond_prev (cond_prev[i]),
            .enable    (en_q[i]),
            .mode      (mode_of(mode_hi_q[i], mode_lo_q[i])),
            .clr       (status_clr),
            .status    (status_q[i])
        );
    end

    evt_out_drive #(.NUM_SRC(NUM_SRC)) drv_i (
        .status (status_q),
        .pol    (pol_q),
        .irq_o  (irq_o),
        .irq_oe (irq_oe)
    );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] cond_i,
    input logic [NUM_SRC-1:0] cond_prev,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] mode_hi_q,
    input logic [NUM_SRC-1:0] mode_lo_q,
    input logic [1:0]         pol_q,
    input logic [NUM_SRC-1:0] status_q,
    input logic               rd_clr,
    input logic               irq_o,
    input logic               irq_oe
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic [1:0] code;
        assign code = {mode_hi_q[i], mode_lo_q[i]};

        assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
            (!en_q[i] || code == 2'b11) |=> !status_q[i]);

        assert_level_R5: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && code == 2'b10) |=> (status_q[i] == $past(cond_i[i])));

        assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && code == 2'b00 && cond_i[i] && !cond_prev[i]) |=> status_q[i]);

        assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && code == 2'b01 && !cond_i[i] && cond_prev[i]) |=> status_q[i]);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && !code[1] && status_q[i] && !rd_clr) |=> status_q[i]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && !code[1] && rd_clr && (cond_i[i] == cond_prev[i])) |=> !status_q[i]);
    end

    assert_high_R10: assert property (@(posedge clk) disable iff (rst)
        (pol_q == 2'b00 || pol_q == 2'b11) |-> (irq_oe && irq_o == (|status_q)));

    assert_low_R10: assert property (@(posedge clk) disable iff (rst)
        (pol_q == 2'b01) |-> (irq_oe && irq_o == !(|status_q)));

    assert_odrain_R10: assert property (@(posedge clk) disable iff (rst)
        (pol_q == 2'b10) |-> (!irq_o && irq_oe == (|status_q)));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cond_i    (cond_i),
    .cond_prev (cond_prev),
    .en_q      (en_q),
    .mode_hi_q (mode_hi_q),
    .mode_lo_q (mode_lo_q),
    .pol_q     (pol_q),
    .status_q  (status_q),
    .rd_clr    (status_clr),
    .irq_o     (irq_o),
    .irq_oe    (irq_oe)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] cond_i;
    logic         reg_wr_en;
    logic         reg_rd_en;
    logic [2:0]   reg_addr;
    logic [N-1:0] reg_wdata;
    logic [N-1:0] reg_rdata;
    logic         irq_o;
    logic         irq_oe;

    always #5 clk = ~clk;

    evt_irq_ctrl #(.NUM_SRC(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond_i),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .irq_oe    (irq_oe)
    );

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    logic [N-1:0] m_en, m_hi, m_lo, m_stat, m_prev;
    logic [1:0]   m_pol;

    function automatic logic [N-1:0] model_next(input logic [N-1:0] c, input logic clr);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic [1:0] code;
            code = {m_hi[i], m_lo[i]};
            if (!m_en[i] || code == 2'b11)  r[i] = 1'b0;
            else if (code == 2'b10)         r[i] = c[i];
            else if (code == 2'b00)         r[i] = (c[i] & ~m_prev[i]) | (m_stat[i] & ~clr);
            else                            r[i] = (~c[i] & m_prev[i]) | (m_stat[i] & ~clr);
        end
        return r;
    endfunction

    function automatic logic [N-1:0] model_reg(input logic [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd1: return m_hi;
            3'd2: return m_lo;
            3'd3: return {{(N-2){1'b0}}, m_pol};
            3'd4: return m_stat;
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] model_pin();
        logic req;
        req = |m_stat;
        case (m_pol)
            2'b01:   return {~req, 1'b1};
            2'b10:   return {1'b0, req};
            default: return {req, 1'b1};
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [N-1:0] c, input logic wr, input logic rd,
                         input logic [2:0] a, input logic [N-1:0] d, input string tag);
        logic [N-1:0] rexp;
        logic [N-1:0] nstat;
        logic [1:0]   pin;
        cond_i    = c;
        reg_wr_en = wr;
        reg_rd_en = rd;
        reg_addr  = a;
        reg_wdata = d;
        rexp  = model_reg(a);
        nstat = model_next(c, rd && a == 3'd4);
        if (wr) begin
            case (a)
                3'd0: m_en  = d;
                3'd1: m_hi  = d;
                3'd2: m_lo  = d;
                3'd3: m_pol = d[1:0];
                default: ;
            endcase
        end
        m_stat = nstat;
        m_prev = c;
        @(posedge clk);
        @(negedge clk);
        pin = model_pin();
        check({tag, " pin"}, {{(N-2){1'b0}}, irq_o, irq_oe}, {{(N-2){1'b0}}, pin});
        if (rd) check({tag, " rdata"}, reg_rdata, rexp);
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [N-1:0] c, input logic [2:0] a, input logic [N-1:0] d, input string tag);
        cycle(c, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd_reg(input logic [N-1:0] c, input logic [2:0] a, input string tag);
        cycle(c, 1'b0, 1'b1, a, '0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_en = '0; m_hi = '0; m_lo = '0; m_stat = '0; m_prev = '0; m_pol = 2'b00;
        rst = 1'b1; cond_i = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        check("R1 reset pin", {{(N-2){1'b0}}, irq_o, irq_oe}, {{(N-2){1'b0}}, 2'b01});
        for (int a = 0; a < 5; a++) rd_reg('0, 3'(a), "R1 reset reg");

        // R2: register map, ignored status write, unmapped address
        wr_reg('0, 3'd0, 8'hA5, "R2 wr en");
        rd_reg('0, 3'd0, "R2 rd en");
        wr_reg('0, 3'd1, 8'h3C, "R2 wr hi");
        wr_reg('0, 3'd2, 8'h0F, "R2 wr lo");
        wr_reg('0, 3'd3, 8'hFE, "R2 wr pol");
        rd_reg('0, 3'd1, "R2 rd hi");
        rd_reg('0, 3'd2, "R2 rd lo");
        rd_reg('0, 3'd3, "R2 rd pol");
        wr_reg('0, 3'd4, 8'hFF, "R2 wr status");
        rd_reg('0, 3'd4, "R2 status ignored");
        rd_reg('0, 3'd7, "R2 unmapped");
        wr_reg('0, 3'd3, 8'h00, "R2 pol back");
        wr_reg('0, 3'd1, 8'h00, "R2 hi clear");
        wr_reg('0, 3'd2, 8'h00, "R2 lo clear");
        wr_reg('0, 3'd0, 8'hFF, "R2 enable all");

        // R3: rising edge sticky, cleared by read
        cycle(8'h01, 1'b0, 1'b0, 3'd0, '0, "R3 rise");
        cycle(8'h01, 1'b0, 1'b0, 3'd0, '0, "R3 R9 held");
        rd_reg(8'h01, 3'd4, "R3 read set");
        rd_reg(8'h01, 3'd4, "R3 read cleared");

        // R4: falling edge
        wr_reg(8'h01, 3'd2, 8'hFF, "R4 mode fall");
        cycle(8'h00, 1'b0, 1'b0, 3'd0, '0, "R4 fall");
        rd_reg(8'h00, 3'd4, "R4 read set");
        rd_reg(8'h00, 3'd4, "R4 read cleared");

        // R5: level mode follows condition, read does not clear
        wr_reg(8'h00, 3'd2, 8'h00, "R5 lo");
        wr_reg(8'h00, 3'd1, 8'hFF, "R5 hi");
        cycle(8'h81, 1'b0, 1'b0, 3'd0, '0, "R5 level on");
        rd_reg(8'h81, 3'd4, "R5 read 1");
        rd_reg(8'h81, 3'd4, "R5 read 2");
        cycle(8'h00, 1'b0, 1'b0, 3'd0, '0, "R5 level off");
        rd_reg(8'h00, 3'd4, "R5 read off");

        // R6: mixed codes: bit0 rise, bit1 fall, bit2 level, bit3 reserved
        wr_reg(8'h00, 3'd1, 8'h0C, "R6 hi");
        wr_reg(8'h00, 3'd2, 8'h0A, "R6 lo");
        cycle(8'h0F, 1'b0, 1'b0, 3'd0, '0, "R6 all up");
        rd_reg(8'h0F, 3'd4, "R6 R7 read up");
        cycle(8'h00, 1'b0, 1'b0, 3'd0, '0, "R6 all down");
        rd_reg(8'h00, 3'd4, "R6 read down");

        // R7: disabling discards latched bit
        wr_reg(8'h00, 3'd1, 8'h00, "R7 hi");
        wr_reg(8'h00, 3'd2, 8'h00, "R7 lo");
        cycle(8'h10, 1'b0, 1'b0, 3'd0, '0, "R7 latch");
        wr_reg(8'h10, 3'd0, 8'hEF, "R7 disable");
        cycle(8'h00, 1'b0, 1'b0, 3'd0, '0, "R7 gone");
        cycle(8'h10, 1'b0, 1'b0, 3'd0, '0, "R7 edge ignored");
        rd_reg(8'h10, 3'd4, "R7 read zero");
        wr_reg(8'h10, 3'd0, 8'hFF, "R7 reenable");

        // R8: edge arriving with the read survives
        cycle(8'h00, 1'b0, 1'b0, 3'd0, '0, "R8 prep");
        rd_reg(8'h20, 3'd4, "R8 collide read");
        rd_reg(8'h20, 3'd4, "R8 survives");
        rd_reg(8'h20, 3'd4, "R8 now cleared");

        // R10: polarity codes with active and idle request
        for (int p = 0; p < 4; p++) begin
            wr_reg(8'h00, 3'd3, 8'(p), "R10 pol");
            cycle(8'h40, 1'b0, 1'b0, 3'd0, '0, "R10 R9 active");
            rd_reg(8'h40, 3'd4, "R10 clear");
            cycle(8'h40, 1'b0, 1'b0, 3'd0, '0, "R10 idle");
        end

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] c;
            int sel;
            c   = (($urandom % 4) == 0) ? N'($urandom) : m_prev ^ N'(1 << ($urandom % N));
            sel = $urandom % 16;
            if (sel == 0)      wr_reg(c, 3'($urandom % 4), N'($urandom), "R2 R6 rnd wr");
            else if (sel < 6)  rd_reg(c, 3'd4, "R3 R4 R5 R8 rnd rd");
            else if (sel == 6) rd_reg(c, 3'($urandom % 8), "R2 rnd rd");
            else               cycle(c, 1'b0, 1'b0, 3'd0, '0, "R7 R9 R10 rnd");
        end

        summary();
        $finish;
    end
endmodule